// File: doc/BRIEF.md
# Block-Copy DMA Engine

This block moves a run of words from one place in the system address space to another with no help from the processor. It has two bus sides. On the target side the host programs four registers: where to read, where to write, how many words to move, and a control word. On the initiator side the engine drives its own request, address and write data, and waits on a ready reply from the system.

The host loads the three transfer registers and then writes the control word with its start bit set. The engine then moves each word as a read at the current source address followed by a write of that same data to the current destination address. Either address can be frozen, so that the engine can drain a device's fixed data register into memory or fill one from memory. When the count reaches zero the engine goes idle and raises a done flag. It also asserts an interrupt if the host enabled that. A start with a count of zero finishes at once and touches no bus.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset the engine is idle, every register reads zero, `m_req` is low and `irq` is low.
- R2: Target offsets are 0 for the source address, 1 for the destination address, 2 for the word count and 3 for control. `t_rdata` shows the addressed register in the same cycle and is zero-extended.
- R3: Control bits are as follows. Bit 0 is start, which always reads 0. Bit 1 is interrupt enable. Bit 2 freezes the source address. Bit 3 freezes the destination address. Bit 4 is done, and writing 1 to it clears it. Bit 5 is busy and is read only.
- R4: Each word is moved as one read (`m_wr`=0) at the source address, then one write (`m_wr`=1) at the destination address carrying the data that was read. A request keeps `m_addr` and `m_wr` steady until `m_ready` is seen high at a clock edge.
- R5: After each completed write, an address that is not frozen advances by one. A frozen address keeps its value.
- R6: The word count drops by one per completed write and can be read back live. The engine goes idle, and busy clears, once the count reaches zero.
- R7: Completion sets done. `irq` equals done AND interrupt enable. Writing 1 to bit 4 drops both done and `irq`, and a start with a nonzero count also clears done.
- R8: While busy, host writes to the source, destination and count registers have no effect. Writes of the start bit and the freeze bits also have no effect.
- R9: A start with a count of zero sets done on the next clock edge and issues no bus access.
- R10: `m_req` is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_wen | input | 1 | Host register write strobe |
| t_addr | input | 2 | Host register offset |
| t_wdata | input | W | Host write data |
| t_rdata | output | W | Host read data for `t_addr` |
| m_req | output | 1 | Initiator access request |
| m_wr | output | 1 | Initiator access is a write |
| m_addr | output | W | Initiator address |
| m_wdata | output | W | Initiator write data |
| m_rdata | input | W | Initiator read data, valid with `m_ready` |
| m_ready | input | 1 | Access completes at this clock edge |
| irq | output | 1 | Completion interrupt |

## Verification
If the sequencer state is wrong, it shows at the initiator port within one access. A read could be followed by another read, an address could move during a stall, or the written data might not match the word just read. If the count or the address registers are wrong, the number of accesses or the address stepping goes wrong. That shows in the memory image and in the final register values as soon as the transfer ends. If the done or enable state is wrong, `irq` shows it the cycle after completion or after a clear. The bench sweeps every count from 0 to 4 against all four freeze combinations and three ready-delay settings. It predicts each access address and each final memory word by arithmetic.

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int W  = 16,
  parameter int LW = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         t_wen,
  input  logic [1:0]   t_addr,
  input  logic [W-1:0] t_wdata,
  output logic [W-1:0] t_rdata,
  output logic         m_req,
  output logic         m_wr,
  output logic [W-1:0] m_addr,
  output logic [W-1:0] m_wdata,
  input  logic [W-1:0] m_rdata,
  input  logic         m_ready,
  output logic         irq
);
  localparam logic [1:0] A_SRC = 2'd0;
  localparam logic [1:0] A_DST = 2'd1;
  localparam logic [1:0] A_LEN = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;
  localparam logic [LW-1:0] LEN_ONE = LW'(1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t          st;
  logic [W-1:0] src_q, dst_q, buf_q;
  logic [LW-1:0] len_q;
  logic         ie_q, sfix_q, dfix_q, done_q;

  wire active = (st != S_IDLE);
  wire ctl_wr = t_wen && (t_addr == A_CTL);
  wire go     = ctl_wr && t_wdata[0] && !active;
  wire wr_ok  = (st == S_WR) && m_ready;
  wire last   = wr_ok && (len_q == LEN_ONE);

  assign m_req   = active;
  assign m_wr    = (st == S_WR);
  assign m_addr  = (st == S_WR) ? dst_q : src_q;
  assign m_wdata = buf_q;
  assign irq     = done_q && ie_q;

  always_comb begin
    case (t_addr)
      A_SRC:   t_rdata = src_q;
      A_DST:   t_rdata = dst_q;
      A_LEN:   t_rdata = W'(len_q);
      default: t_rdata = W'({active, done_q, dfix_q, sfix_q, ie_q, 1'b0});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      buf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (go && len_q != '0) st <= S_RD;
        S_RD: if (m_ready) begin
          buf_q <= m_rdata;
          st    <= S_WR;
        end
        default: if (m_ready) st <= last ? S_IDLE : S_RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
    end else if (!active) begin
      if (t_wen && t_addr == A_SRC) src_q <= t_wdata;
      if (t_wen && t_addr == A_DST) dst_q <= t_wdata;
      if (t_wen && t_addr == A_LEN) len_q <= t_wdata[LW-1:0];
    end else if (wr_ok) begin
      if (!sfix_q) src_q <= src_q + W'(1);
      if (!dfix_q) dst_q <= dst_q + W'(1);
      len_q <= len_q - LEN_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      sfix_q <= 1'b0;
      dfix_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ie_q <= t_wdata[1];
        if (!active) begin
          sfix_q <= t_wdata[2];
          dfix_q <= t_wdata[3];
        end
      end
      if (last || (go && len_q == '0)) done_q <= 1'b1;
      else if (go)                     done_q <= 1'b0;
      else if (ctl_wr && t_wdata[4])   done_q <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_wr)); // R4
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_wr && m_ready |=> m_req && m_wr); // R4
  AST_WDATA_FROM_RD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_wr && m_ready |=> m_wdata == $past(m_rdata)); // R4
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_wr && m_ready |=> len_q == $past(len_q) - LEN_ONE); // R6
  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_wr && m_ready && sfix_q |=> src_q == $past(src_q)); // R5
  AST_DST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    active && t_wen && t_addr == A_DST && !wr_ok |=> dst_q == $past(dst_q)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    go && len_q == '0 |=> !m_req && done_q); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && t_wdata[4] && !last && !go |=> !irq); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !m_req && done_q); // R10
endmodule

// File: tb/sim_dma_copy_engine.sv
`timescale 1ns/1ps
module sim_dma_copy_engine;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t_wen = 1'b0;
  logic [1:0] t_addr = 2'd0;
  logic [W-1:0] t_wdata = '0;
  logic [W-1:0] t_rdata;
  logic m_req, m_wr;
  logic [W-1:0] m_addr, m_wdata;
  logic [W-1:0] m_rdata = '0;
  logic m_ready = 1'b0;
  logic irq;

  dma_copy_engine #(.W(W), .LW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .t_wen(t_wen), .t_addr(t_addr), .t_wdata(t_wdata),
    .t_rdata(t_rdata), .m_req(m_req), .m_wr(m_wr), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .irq(irq));

  always #2.5 clk = ~clk;

  int total = 0;
  int fails = 0;
  logic [W-1:0] mem [0:255];
  int wt = 0, cnt = 0, nr = 0, nw = 0, seq_err = 0;
  int src0 = 0, dst0 = 0;
  bit sfix = 0, dfix = 0;

  function automatic logic [W-1:0] pat(input int a);
    return W'(a * 37 + 261);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(negedge clk) begin
    if (m_req) begin
      if (cnt == wt) begin
        m_ready = 1'b1;
        m_rdata = mem[m_addr[7:0]];
        cnt = 0;
      end else begin
        m_ready = 1'b0;
        cnt++;
      end
    end else begin
      m_ready = 1'b0;
      cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && m_req && m_ready) begin
      if (m_wr) begin
        if (int'(m_addr) != dst0 + (dfix ? 0 : nw)) seq_err++;
        if (m_wdata != pat(src0 + (sfix ? 0 : nw))) seq_err++;
        mem[m_addr[7:0]] = m_wdata;
        nw++;
      end else begin
        if (int'(m_addr) != src0 + (sfix ? 0 : nr)) seq_err++;
        nr++;
      end
    end
  end

  task automatic hw(input logic [1:0] a, input int d);
    @(negedge clk);
    t_wen = 1'b1; t_addr = a; t_wdata = W'(d);
    @(negedge clk);
    t_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    t_addr = a;
    #1;
    d = int'(t_rdata);
  endtask

  task automatic run(input int len, input int fix, input int wdel, input bit ie);
    int v, polls, mm;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    wt = wdel; nr = 0; nw = 0; seq_err = 0;
    sfix = fix[0]; dfix = fix[1];
    src0 = 16 + len; dst0 = 128 + fix * 3;
    hw(0, src0); hw(1, dst0); hw(2, len);
    rd(0, v); chk("R2 src readback", v, src0);
    rd(1, v); chk("R2 dst readback", v, dst0);
    rd(2, v); chk("R2 len readback", v, len);
    hw(3, 1 | (int'(ie) << 1) | (fix << 2));
    if (len > 0) begin
      rd(3, v);
      chk("R3 busy and fields", v & 16'h2F, 32 | (int'(ie) << 1) | (fix << 2));
    end
    if (len >= 3) begin
      hw(0, 16'h00F0); hw(1, 16'h00F8); hw(2, 7);
      hw(3, 1 | (int'(ie) << 1) | ((~fix & 3) << 2));
    end
    polls = 0;
    rd(3, v);
    while (!v[4] && polls < 400) begin
      @(negedge clk); polls++; rd(3, v);
    end
    if (len == 0) begin
      chk("R9 zero length done at once", polls, 0);
      chk("R9 no access", nr + nw, 0);
    end
    chk("R7 done set", v[4], 1);
    chk("R6 busy clear", v[5], 0);
    chk("R7 irq follows enable", int'(irq), int'(ie));
    chk("R10 no request idle", int'(m_req), 0);
    chk("R4 read count", nr, len);
    chk("R4 write count", nw, len);
    chk("R4 R5 access sequence", seq_err, 0);
    rd(2, v); chk("R6 len at end", v, 0);
    rd(0, v); chk("R5 R8 src at end", v, src0 + (sfix ? 0 : len));
    rd(1, v); chk("R5 R8 dst at end", v, dst0 + (dfix ? 0 : len));
    mm = 0;
    if (dfix) begin
      if (len > 0 && mem[dst0] != pat(src0 + (sfix ? 0 : len - 1))) mm++;
      if (len == 0 && mem[dst0] != pat(dst0)) mm++;
      if (mem[dst0 + 1] != pat(dst0 + 1)) mm++;
    end else begin
      for (int k = 0; k < len; k++)
        if (mem[dst0 + k] != pat(src0 + (sfix ? 0 : k))) mm++;
      if (mem[dst0 + len] != pat(dst0 + len)) mm++;
    end
    if (mem[8'hF8] != pat(16'hF8)) mm++;
    chk("R4 R8 memory image", mm, 0);
    hw(3, 16 | (int'(ie) << 1));
    rd(3, v);
    chk("R7 done cleared", v[4], 0);
    chk("R7 irq cleared", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 register reset", v, 0);
    end
    chk("R1 no request", int'(m_req), 0);
    chk("R1 irq low", int'(irq), 0);
    for (int len = 0; len < 5; len++)
      for (int fix = 0; fix < 4; fix++)
        for (int wdel = 0; wdel < 3; wdel++)
          run(len, fix, wdel, bit'((len + fix + wdel) % 2));
    finish_run();
  end
endmodule